// File: doc/BRIEF.md
# Parallel Converter Sequencer

This block is a clocked host-side controller for a sampling analog-to-digital converter with a parallel result bus. A start comes from a one-cycle trigger input or from an internal free-running pacer. For each start, the block drives the converter's active-low read/convert line and its chip select in the order the converter requires. It then waits for the converter's busy line to return high. Finally it fetches the 16-bit result, either as a full word or as two bytes over one 8-bit lane. The finished sample leaves as a one-cycle valid pulse with a signed 16-bit value.

Every converter timing rule is a parameter counted in clock cycles:
- the convert pulse width,
- the lead of read/convert over chip select,
- the minimum spacing between convert commands,
- the bus enable delay,
- the byte-switch delay.

After reset, and whenever it is asked to, the block issues an abort pulse that terminates any conversion in progress. It uses the same abort to recover when the busy line stays low for longer than a parameterised limit. All three control outputs come straight from flops. The busy input passes through a two-flop synchronizer.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted the outputs sit at their idle levels: cnv_n_o=1, cs_n_o=1, byte_sel_o=0, smp_valid_o=0, overrun_o=0, timeout_o=0.
- R2: After reset is released, and after any cycle with init_req_i=1, cnv_n_o goes low for at least CNV_LOW_CYC cycles while cs_n_o stays high. A conversion in progress is terminated by this abort and delivers no sample.
- R3: For a convert command, cnv_n_o falls at least SETUP_CYC cycles before cs_n_o falls. Both lines then stay low together for at least CNV_LOW_CYC cycles, and afterwards both return high.
- R4: Consecutive convert commands are at least CYCLE_CYC cycles apart, measured between falling edges of cnv_n_o. The same spacing holds from an abort to the next convert command.
- R5: The result bus is read (cs_n_o=0 with cnv_n_o=1) only after busy_i has returned high following the conversion, and never while busy_i is low.
- R6: In word mode (byte_mode_i=0 at start), all 16 bits of data_i are captured EN_CYC cycles after cs_n_o falls for the read. They form the sample.
- R7: In byte mode (byte_mode_i=1 at start), the 8-bit lane is data_i[15:8].
  - The high byte is captured with byte_sel_o=0, EN_CYC cycles after cs_n_o falls.
  - byte_sel_o then goes to 1, and the low byte is captured BYTE_CYC cycles later.
  - The sample is {high byte, low byte}.
- R8: Each completed read produces exactly one cycle of smp_valid_o=1. smp_data_o carries the two's-complement sample and holds it until the next one.
- R9: A trigger that arrives while a sequence is active, or while a trigger is already pending, is dropped. It raises overrun_o for one cycle.
- R10: If a conversion does not finish within TIMEOUT_CYC cycles of the start of the busy wait, timeout_o pulses for one cycle and an abort is issued.
- R11: With auto_en_i=1, the internal pacer starts a conversion every AUTO_PERIOD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | One-cycle start request |
| auto_en_i | input | 1 | Enables periodic starts from the pacer |
| byte_mode_i | input | 1 | 1 selects two byte reads, 0 selects one word read |
| init_req_i | input | 1 | Requests an abort of the converter |
| busy_i | input | 1 | Converter busy line, low while converting (asynchronous) |
| data_i | input | 16 | Converter parallel result bus |
| cnv_n_o | output | 1 | Read/convert line, low to convert or abort |
| cs_n_o | output | 1 | Chip select, active low |
| byte_sel_o | output | 1 | Byte select: 0 puts the high byte on the lane, 1 the low byte |
| smp_valid_o | output | 1 | One-cycle sample valid pulse |
| smp_data_o | output | 16 | Signed sample |
| overrun_o | output | 1 | One-cycle pulse for a dropped trigger |
| timeout_o | output | 1 | One-cycle pulse when the busy wait expires |

## Verification
Several properties are checked on every cycle by the assertions:
- read/convert leads chip select when a convert begins;
- a read only ever follows a cycle in which the synchronized busy line was high;
- the byte select is raised only during a read;
- the valid pulse never lasts two cycles;
- an expired busy wait always coincides with an abort on the control lines.

Other behaviour can only be shown by the bench's scenarios, which run against a behavioural converter model:
- the captured values across a sweep of codes that includes both full-scale ends and the sign boundary, in both read modes;
- the exact bus enable and byte-switch delays, because the model drives garbage until each delay has elapsed;
- command spacing;
- overrun and timeout counts;
- the pacer period.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the converter sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_seq_pkg;

    // Sequencer phases, from abort through the two read phases.
    typedef enum logic [2:0] {
        ST_ABORT = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SETUP = 3'd2,
        ST_PULSE = 3'd3,
        ST_WLO   = 3'd4,
        ST_WHI   = 3'd5,
        ST_RD1   = 3'd6,
        ST_RD2   = 3'd7
    } seq_state_t;

endpackage

// File: rtl/seq_busy_sync.sv
// Module: multi-flop synchronizer for the converter busy line.
// Assumes: STAGES >= 2. The reset value is 1, which is the converter's idle level.
module seq_busy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], async_i};
    end

    assign sync_o = sh_q[STAGES-1];

endmodule

// File: rtl/seq_pacer.sv
// Module: free-running start pacer.
// While en_i is high it emits one registered tick every PERIOD cycles.
// Its phase restarts whenever en_i drops.
// Assumes: PERIOD >= 2.
module seq_pacer #(
    parameter int unsigned PERIOD = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt_q;
    logic          tick_q;

    // Count cycles while enabled and flag the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == CW'(PERIOD - 1)) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/seq_core.sv
// Module: the converter control state machine.
// It issues convert and abort pulses, waits on the synchronized busy level,
// reads the result as a word or as two bytes from the upper lane, and
// delivers the sample. All control outputs are registered from the next state.
// Assumes: every *_CYC parameter >= 1, and DATA_W is even.
module seq_core
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned CNV_LOW_CYC = 3,
    parameter int unsigned CYCLE_CYC   = 30,
    parameter int unsigned EN_CYC      = 2,
    parameter int unsigned BYTE_CYC    = 2,
    parameter int unsigned TIMEOUT_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              init_req_i,
    input  logic              byte_mode_i,
    input  logic              busy_s_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cnv_n_o,
    output logic              cs_n_o,
    output logic              byte_sel_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              overrun_o,
    output logic              timeout_o
);

    localparam int unsigned LANE_W = DATA_W / 2;
    localparam int unsigned DUR_W  = $clog2(SETUP_CYC + CNV_LOW_CYC + EN_CYC + BYTE_CYC + 1);
    localparam int unsigned SPC_W  = $clog2(CYCLE_CYC + 1);
    localparam int unsigned TMO_W  = $clog2(TIMEOUT_CYC + 1);

    seq_state_t        state_q, state_d;
    logic [DUR_W-1:0]  dur_q;
    logic [SPC_W-1:0]  spc_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              boot_q, pend_q, mode_q;
    logic              cnv_n_q, cs_n_q, bsel_q, valid_q, ovr_q, tmo_ev_q;
    logic [LANE_W-1:0] hi_q;
    logic [DATA_W-1:0] data_q;
    logic              abort_req, tmo_hit, tmo_fire, accept, start, enter;
    logic [LANE_W-1:0] lane;

    // Length in cycles, minus one, of each timed phase.
    function automatic logic [DUR_W-1:0] dur_of(input seq_state_t s);
        case (s)
            ST_ABORT, ST_PULSE: return DUR_W'(CNV_LOW_CYC - 1);
            ST_SETUP:           return DUR_W'(SETUP_CYC - 1);
            ST_RD1:             return DUR_W'(EN_CYC - 1);
            ST_RD2:             return DUR_W'(BYTE_CYC - 1);
            default:            return '0;
        endcase
    endfunction

    assign abort_req = init_req_i | boot_q;
    assign tmo_hit   = (tmo_q == TMO_W'(TIMEOUT_CYC - 1));
    assign lane      = data_i[DATA_W-1 -: LANE_W];
    assign accept    = trig_i && (state_q == ST_IDLE) && !pend_q;
    assign start     = (state_q == ST_IDLE) && (state_d == ST_SETUP);
    assign enter     = (state_d != state_q);

    // Next-state selection. An abort request overrides every phase.
    always_comb begin
        state_d  = state_q;
        tmo_fire = 1'b0;
        unique case (state_q)
            ST_ABORT: if (dur_q == '0) state_d = ST_IDLE;
            ST_IDLE:  if (pend_q && spc_q == '0) state_d = ST_SETUP;
            ST_SETUP: if (dur_q == '0) state_d = ST_PULSE;
            ST_PULSE: if (dur_q == '0) state_d = ST_WLO;
            ST_WLO: begin
                if (!busy_s_i) state_d = ST_WHI;
                else if (tmo_hit) begin
                    state_d  = ST_ABORT;
                    tmo_fire = 1'b1;
                end
            end
            ST_WHI: begin
                if (busy_s_i) state_d = ST_RD1;
                else if (tmo_hit) begin
                    state_d  = ST_ABORT;
                    tmo_fire = 1'b1;
                end
            end
            ST_RD1:   if (dur_q == '0) state_d = mode_q ? ST_RD2 : ST_IDLE;
            ST_RD2:   if (dur_q == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (abort_req) state_d = ST_ABORT;
    end

    // State, phase duration and one-shot boot abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dur_q   <= '0;
            boot_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (enter)              dur_q <= dur_of(state_d);
            else if (dur_q != '0)   dur_q <= dur_q - 1'b1;
            if (state_d == ST_ABORT) boot_q <= 1'b0;
        end
    end

    // Command spacing: reload on each convert or abort, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           spc_q <= '0;
        else if (enter && (state_d == ST_SETUP || state_d == ST_ABORT)) spc_q <= SPC_W'(CYCLE_CYC - 1);
        else if (spc_q != '0)                                 spc_q <= spc_q - 1'b1;
    end

    // Busy-wait timer, counting only in the two wait phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !(state_q == ST_WLO || state_q == ST_WHI)) tmo_q <= '0;
        else                                                     tmo_q <= tmo_q + 1'b1;
    end

    // Pending trigger, overrun detection and capture of the read mode at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            ovr_q <= trig_i && !accept;
            if (state_d == ST_ABORT) pend_q <= 1'b0;
            else if (accept)         pend_q <= 1'b1;
            else if (start)          pend_q <= 1'b0;
            if (start) mode_q <= byte_mode_i;
        end
    end

    // Registered control lines, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_n_q  <= 1'b1;
            cs_n_q   <= 1'b1;
            bsel_q   <= 1'b0;
            tmo_ev_q <= 1'b0;
        end else begin
            cnv_n_q  <= !(state_d == ST_ABORT || state_d == ST_SETUP || state_d == ST_PULSE);
            cs_n_q   <= !(state_d == ST_PULSE || state_d == ST_RD1 || state_d == ST_RD2);
            bsel_q   <= (state_d == ST_RD2);
            tmo_ev_q <= tmo_fire;
        end
    end

    // Result capture and sample delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (state_q == ST_RD1 && state_d == ST_RD2) hi_q <= lane;
            if (state_q == ST_RD1 && state_d == ST_IDLE) begin
                data_q  <= data_i;
                valid_q <= 1'b1;
            end
            if (state_q == ST_RD2 && state_d == ST_IDLE) begin
                data_q  <= {hi_q, lane};
                valid_q <= 1'b1;
            end
        end
    end

    assign cnv_n_o    = cnv_n_q;
    assign cs_n_o     = cs_n_q;
    assign byte_sel_o = bsel_q;
    assign valid_o    = valid_q;
    assign data_o     = data_q;
    assign overrun_o  = ovr_q;
    assign timeout_o  = tmo_ev_q;

    // R3: chip select falling on a convert command follows read/convert already low.
    p_cnv_leads_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_q) && !cnv_n_q) |-> $past(!cnv_n_q));

    // R5: a read phase opens only after the synchronized busy line was seen high.
    p_read_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_q) && cnv_n_q) |-> $past(busy_s_i));

    // R7: the byte select is raised only inside a read.
    p_bsel_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bsel_q |-> (!cs_n_q && cnv_n_q));

    // R8: the sample valid pulse lasts one cycle.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R10: an expired busy wait comes with an abort pulse and chip select high.
    p_timeout_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_ev_q |-> (!cnv_n_q && cs_n_q));

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the parallel converter sequencer.
// It joins the busy synchronizer, the start pacer and the control state machine.
// Assumes: the timing parameters are already converted to clock cycles,
// and AUTO_PERIOD exceeds the length of one full sequence.
module adc_seq_ctrl #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned CNV_LOW_CYC = 3,
    parameter int unsigned CYCLE_CYC   = 30,
    parameter int unsigned EN_CYC      = 2,
    parameter int unsigned BYTE_CYC    = 2,
    parameter int unsigned TIMEOUT_CYC = 40,
    parameter int unsigned AUTO_PERIOD = 60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig_i,
    input  logic                     auto_en_i,
    input  logic                     byte_mode_i,
    input  logic                     init_req_i,
    input  logic                     busy_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic                     cnv_n_o,
    output logic                     cs_n_o,
    output logic                     byte_sel_o,
    output logic                     smp_valid_o,
    output logic signed [DATA_W-1:0] smp_data_o,
    output logic                     overrun_o,
    output logic                     timeout_o
);

    logic              busy_s;
    logic              pace_tick;
    logic              trig_any;
    logic [DATA_W-1:0] smp_raw;

    seq_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (busy_i),
        .sync_o  (busy_s)
    );

    seq_pacer #(.PERIOD(AUTO_PERIOD)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (auto_en_i),
        .tick_o (pace_tick)
    );

    assign trig_any = trig_i | pace_tick;

    seq_core #(
        .DATA_W      (DATA_W),
        .SETUP_CYC   (SETUP_CYC),
        .CNV_LOW_CYC (CNV_LOW_CYC),
        .CYCLE_CYC   (CYCLE_CYC),
        .EN_CYC      (EN_CYC),
        .BYTE_CYC    (BYTE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_any),
        .init_req_i  (init_req_i),
        .byte_mode_i (byte_mode_i),
        .busy_s_i    (busy_s),
        .data_i      (data_i),
        .cnv_n_o     (cnv_n_o),
        .cs_n_o      (cs_n_o),
        .byte_sel_o  (byte_sel_o),
        .valid_o     (smp_valid_o),
        .data_o      (smp_raw),
        .overrun_o   (overrun_o),
        .timeout_o   (timeout_o)
    );

    assign smp_data_o = $signed(smp_raw);

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
// Bench: drives the sequencer against a behavioural converter model that
// enforces the timing rules and drives garbage on the bus until the
// enable and byte-switch delays have elapsed.
module adc_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETUP  = 2;
    localparam int CLOW   = 3;
    localparam int CYC    = 30;
    localparam int EN     = 2;
    localparam int BSW    = 2;
    localparam int TMO    = 40;
    localparam int APER   = 60;
    localparam int CONV   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 1'b0, auto_en_i = 1'b0, byte_mode_i = 1'b0, init_req_i = 1'b0;
    logic busy_i = 1'b1;
    logic [15:0] data_i = 16'h0;
    logic cnv_n_o, cs_n_o, byte_sel_o, smp_valid_o, overrun_o, timeout_o;
    logic signed [15:0] smp_data_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(
        .DATA_W(16), .SYNC_STAGES(2), .SETUP_CYC(SETUP), .CNV_LOW_CYC(CLOW),
        .CYCLE_CYC(CYC), .EN_CYC(EN), .BYTE_CYC(BSW), .TIMEOUT_CYC(TMO), .AUTO_PERIOD(APER)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .auto_en_i(auto_en_i),
        .byte_mode_i(byte_mode_i), .init_req_i(init_req_i), .busy_i(busy_i), .data_i(data_i),
        .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o), .byte_sel_o(byte_sel_o), .smp_valid_o(smp_valid_o),
        .smp_data_o(smp_data_o), .overrun_o(overrun_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Code sequence produced by the model: corner codes first, then a stride sweep.
    function automatic logic [15:0] code_of(input int k);
        logic [31:0] t;
        case (k)
            0: return 16'h7FFF;
            1: return 16'h8000;
            2: return 16'hFFFF;
            3: return 16'h0000;
            4: return 16'h0001;
            default: begin
                t = k * 32'h2F3B + 32'h1357;
                return t[15:0];
            end
        endcase
    endfunction

    // Model state
    int  cyc = 0, cnv_run = 0, both_run = 0, left = 0;
    int  last_fall = 0, prev_fall = 0, last_start_cyc = 0, last_gap = 0;
    bit  have_last = 0, have_prev = 0, cs_in_pulse = 0;
    bit  prev_cnv = 1, prev_both = 0, prev_bsel = 0, prev_valid = 0, stuck = 0;
    int  starts = 0, aborts = 0, lone = 0, vcnt = 0, ovr_cnt = 0, tmo_cnt = 0;
    int  done_idx = 0, got_idx = 0, en_cnt = 0, bsel_cnt = 100;
    logic [15:0] result = 16'h0;

    // Converter model and timing monitors, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_i = 1'b1;
            cnv_run = 0; both_run = 0; prev_cnv = 1; prev_both = 0; en_cnt = 0;
        end else begin
            bit both;
            cyc++;
            both = !cnv_n_o && !cs_n_o;
            if (!cnv_n_o && prev_cnv) begin
                prev_fall = last_fall; last_fall = cyc;
                have_prev = have_last; have_last = 1; cs_in_pulse = 0;
            end
            if (both) cs_in_pulse = 1;
            if (cnv_n_o && !prev_cnv && !cs_in_pulse) begin
                lone++;
                chk(cnv_run >= CLOW, "R2 abort pulse width", cnv_run, CLOW);
            end
            if (!cnv_n_o && prev_cnv && !busy_i) begin
                busy_i = 1'b1; aborts++;
            end else if (both && !prev_both && busy_i) begin
                starts++;
                chk(cnv_run >= SETUP, "R3 read/convert lead", cnv_run, SETUP);
                if (have_prev) chk(last_fall - prev_fall >= CYC, "R4 command spacing", last_fall - prev_fall, CYC);
                last_gap = cyc - last_start_cyc; last_start_cyc = cyc;
                busy_i = 1'b0; left = CONV;
            end else if (!busy_i && !stuck) begin
                left--;
                if (left == 0) begin
                    busy_i = 1'b1; result = code_of(done_idx); done_idx++;
                end
            end
            if (prev_both && !both) chk(both_run >= CLOW, "R3 convert pulse width", both_run, CLOW);
            if (!cs_n_o && cnv_n_o) chk(busy_i, "R5 read while busy low", busy_i, 1);
            // Bus model
            en_cnt   = (!cs_n_o && cnv_n_o) ? en_cnt + 1 : 0;
            bsel_cnt = (byte_sel_o != prev_bsel) ? 1 : ((bsel_cnt < 100) ? bsel_cnt + 1 : 100);
            if (en_cnt >= EN && bsel_cnt >= BSW)
                data_i = byte_sel_o ? {result[7:0], result[15:8]} : result;
            else
                data_i = result ^ 16'hA5C3;
            // Output observation
            if (smp_valid_o) begin
                vcnt++;
                chk(smp_data_o == $signed(code_of(got_idx)),
                    byte_mode_i ? "R7 byte-mode sample" : "R6 word-mode sample",
                    int'(smp_data_o), int'($signed(code_of(got_idx))));
                chk(!prev_valid, "R8 valid single cycle", prev_valid, 0);
                got_idx++;
            end
            if (overrun_o) ovr_cnt++;
            if (timeout_o) tmo_cnt++;
            cnv_run  = !cnv_n_o ? cnv_run + 1 : 0;
            both_run = both ? both_run + 1 : 0;
            prev_cnv = cnv_n_o; prev_both = both; prev_bsel = byte_sel_o; prev_valid = smp_valid_o;
        end
    end

    task automatic pulse_trig();
        @(negedge clk) trig_i = 1'b1;
        @(negedge clk) trig_i = 1'b0;
    endtask

    task automatic run_conv(input bit mode, input string tag);
        int v0;
        v0 = vcnt;
        @(negedge clk) byte_mode_i = mode;
        pulse_trig();
        for (int i = 0; i < 150 && vcnt == v0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(vcnt == v0 + 1, tag, vcnt - v0, 1);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0, o0, a0, t0, s0;
        repeat (4) @(negedge clk);
        chk(cnv_n_o && cs_n_o && !byte_sel_o && !smp_valid_o && !overrun_o && !timeout_o,
            "R1 idle outputs in reset", {cnv_n_o, cs_n_o, byte_sel_o, smp_valid_o, overrun_o, timeout_o}, 6'b110000);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(lone == 1, "R2 boot abort pulse", lone, 1);
        chk(starts == 0, "R2 boot abort starts nothing", starts, 0);
        repeat (30) @(negedge clk);

        // Word and byte reads over corner codes and a stride sweep
        for (int i = 0; i < 4; i++) run_conv(1'b0, "R6 word read completes");
        for (int i = 0; i < 4; i++) run_conv(1'b1, "R7 byte read completes");
        for (int i = 0; i < 30; i++) run_conv(i % 3 == 0, "R6 R7 mixed sweep completes");

        // Overrun during an active sequence
        repeat (35) @(negedge clk);
        v0 = vcnt; o0 = ovr_cnt;
        pulse_trig();
        repeat (10) @(negedge clk);
        pulse_trig();
        repeat (60) @(negedge clk);
        chk(ovr_cnt == o0 + 1, "R9 overrun while active", ovr_cnt - o0, 1);
        chk(vcnt == v0 + 1, "R9 dropped trigger gives no sample", vcnt - v0, 1);

        // Overrun from back-to-back triggers while idle
        v0 = vcnt; o0 = ovr_cnt;
        @(negedge clk) trig_i = 1'b1;
        @(negedge clk);
        @(negedge clk) trig_i = 1'b0;
        repeat (80) @(negedge clk);
        chk(ovr_cnt == o0 + 1, "R9 overrun on pending trigger", ovr_cnt - o0, 1);
        chk(vcnt == v0 + 1, "R9 one sample for two triggers", vcnt - v0, 1);

        // Busy timeout with a stuck converter
        v0 = vcnt; a0 = aborts; t0 = tmo_cnt;
        stuck = 1;
        pulse_trig();
        repeat (80) @(negedge clk);
        stuck = 0;
        chk(tmo_cnt == t0 + 1, "R10 timeout pulse", tmo_cnt - t0, 1);
        chk(aborts == a0 + 1, "R10 abort after timeout", aborts - a0, 1);
        chk(vcnt == v0, "R10 no sample on timeout", vcnt - v0, 0);
        run_conv(1'b0, "R10 recovery after timeout");

        // Abort on request during a conversion
        repeat (35) @(negedge clk);
        v0 = vcnt; a0 = aborts; t0 = tmo_cnt;
        pulse_trig();
        repeat (10) @(negedge clk);
        @(negedge clk) init_req_i = 1'b1;
        @(negedge clk) init_req_i = 1'b0;
        repeat (60) @(negedge clk);
        chk(aborts == a0 + 1, "R2 requested abort ends conversion", aborts - a0, 1);
        chk(vcnt == v0, "R2 no sample after abort", vcnt - v0, 0);
        chk(tmo_cnt == t0, "R2 abort raises no timeout", tmo_cnt - t0, 0);
        run_conv(1'b1, "R2 recovery after abort");

        // Free-running pacer
        repeat (35) @(negedge clk);
        s0 = starts; v0 = vcnt; o0 = ovr_cnt;
        @(negedge clk) auto_en_i = 1'b1;
        repeat (400) @(negedge clk);
        @(negedge clk) auto_en_i = 1'b0;
        repeat (100) @(negedge clk);
        chk(starts - s0 == 6, "R11 pacer start count", starts - s0, 6);
        chk(last_gap == APER, "R11 pacer start interval", last_gap, APER);
        chk(vcnt - v0 == starts - s0, "R11 every paced start delivers", vcnt - v0, starts - s0);
        chk(ovr_cnt == o0, "R11 pacer without overrun", ovr_cnt - o0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule